// File: doc/BRIEF.md
# Interrupt Event Queue Writer

This block turns per-channel receive and transmit events from a multichannel serial controller into 32-bit records. It writes each record into a circular table held in an on-chip RAM, using one single-port word interface. Two sources feed it. An external event port carries a channel number and eight event flags under a valid/ready handshake. A built-in pattern tracker watches the 16-bit line patterns reported per channel and raises its own "line went idle" and "line active" events.

Software owns each table slot whenever the slot's valid bit is clear. After the writer fills a slot it sets that bit. Software reads the record and then clears the bit. The end of the ring is not a length setting. It is a wrap bit that software leaves set in the final slot. After writing that slot, the writer reloads its pointer from a base-address input. Before every write the writer reads the target slot. If software has not yet released the slot, the writer holds off the requester, retries, and latches a sticky overflow indication.

The controller has three named states. IDLE waits for a request. READ drives the slot address to fetch the slot's control bits. CHECK either writes the record or gives up for now. The named transitions are: IDLE to READ (request pending), READ to CHECK (always), CHECK to IDLE (slot free, record written) and CHECK to READ (slot still held, retry).

Top module: `evq_writer`

## Requirements
- R1: Each written record has the valid bit (word bit 31) at 1, the channel number in word bits 12:5, event-flag inputs 7:6 in word bits 25:24 and event-flag inputs 5:0 in word bits 21:16.
- R2: Word bits 29:26, 23:22, 15:13 and 4:0 of every written record are 0. Word bit 30 (wrap) is copied from the wrap bit just read from that slot.
- R3: After writing a slot whose wrap bit was 0, the next record goes to the following word address. After writing a slot whose wrap bit was 1, the next record goes to `base_addr`.
- R4: If the slot read back has its valid bit at 1, the slot is not written and the requester sees no ready. `overflow` goes to 1 and stays at 1 until reset. The pending record is written once software clears the valid bit.
- R5: At most one record is written per grant. When an external event and a tracker event are both pending, the external event is written first.
- R6: A pattern of 0xFFFE on a channel produces a record with only flag input 3 set (word bit 19), but only if that channel has seen no idle pattern since reset or since its last non-idle pattern. A repeated idle produces no record.
- R7: Every pattern other than 0xFFFE produces a record with only flag input 4 set (word bit 20) and re-arms idle detection for that channel.
- R8: Synchronous active-high `rst` loads the write pointer from `base_addr`, clears `overflow` and clears the idle history of all channels.
- R9: A write happens only in CHECK. It goes to the same address that was read in the cycle before, and it is preceded by a cycle without a write. The port shows `mem_we` low in IDLE and READ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_addr | input | AW | Word address of the first table slot |
| ev_valid | input | 1 | External event request valid |
| ev_ready | output | 1 | External event accepted (record written) |
| ev_chan | input | 8 | Channel number of the external event |
| ev_flags | input | 8 | Event flags (mapping in R1) |
| pat_valid | input | 1 | Line pattern report valid |
| pat_ready | output | 1 | Tracker can take a pattern report |
| pat_chan | input | 8 | Channel of the pattern report |
| pat_word | input | 16 | Observed 16-bit line pattern |
| mem_addr | output | AW | RAM word address |
| mem_we | output | 1 | RAM write enable (read when low) |
| mem_wdata | output | 32 | Record written to RAM |
| slot_ctl_rd | input | 2 | Valid and wrap bits of the word read last cycle, {bit31, bit30} |
| overflow | output | 1 | Sticky: a full slot was found |

## Verification
A wrong write pointer shows up on `mem_addr` at the very next READ, one cycle after the request is seen, so a missed wrap or a missed reload puts the next record in the wrong slot. A corrupt idle-history bit shows up within about four cycles of a pattern report: a record appears that should not, or an expected record is missing. A fault in the full check shows up as an overwritten unreleased slot, or as `ev_ready` pulsing while the slot is still held.

// File: rtl/evq_pkg.sv
package evq_pkg;

    localparam int WORD_W = 32;
    localparam int CH_W   = 8;
    localparam int FLG_W  = 8;

    localparam int VLD_BIT  = 31;
    localparam int WRAP_BIT = 30;

    localparam logic [WORD_W-1:0] RSV_MASK  = 32'h3CC0_E01F;
    localparam logic [15:0]       IDLE_PAT  = 16'hFFFE;
    localparam logic [FLG_W-1:0]  FLG_ACT   = 8'h10;
    localparam logic [FLG_W-1:0]  FLG_QUIET = 8'h08;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_CHECK = 2'd2
    } evq_state_t;

    function automatic logic [WORD_W-1:0] pack_entry(
        input logic [CH_W-1:0]  chan,
        input logic [FLG_W-1:0] flags,
        input logic             wrap
    );
        return {1'b1, wrap, 4'b0000, flags[7:6], 2'b00, flags[5:0],
                3'b000, chan, 5'b00000};
    endfunction

endpackage

// File: rtl/evq_idle_track.sv
module evq_idle_track
    import evq_pkg::*;
#(
    parameter int CHAN_W = CH_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pat_valid,
    output logic              pat_ready,
    input  logic [CHAN_W-1:0] pat_chan,
    input  logic [15:0]       pat_word,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [CHAN_W-1:0] req_chan,
    output logic [FLG_W-1:0]  req_flags
);
    localparam int NCH = 1 << CHAN_W;

    // one bit per channel: idle already reported since last activity
    logic [NCH-1:0]    quiet_seen;
    logic              pend_v;
    logic [CHAN_W-1:0] pend_chan;
    logic [FLG_W-1:0]  pend_flags;
    logic              is_quiet;

    assign is_quiet  = (pat_word == IDLE_PAT);
    assign pat_ready = !pend_v;
    assign req_valid = pend_v;
    assign req_chan  = pend_chan;
    assign req_flags = pend_flags;

    always_ff @(posedge clk) begin
        if (rst) begin
            quiet_seen <= '0;
            pend_v     <= 1'b0;
            pend_chan  <= '0;
            pend_flags <= '0;
        end else begin
            if (pend_v && req_ready) begin
                pend_v <= 1'b0;
            end
            if (pat_valid && pat_ready) begin
                if (is_quiet) begin
                    if (!quiet_seen[pat_chan]) begin
                        pend_v     <= 1'b1;
                        pend_chan  <= pat_chan;
                        pend_flags <= FLG_QUIET;
                    end
                    quiet_seen[pat_chan] <= 1'b1;
                end else begin
                    pend_v               <= 1'b1;
                    pend_chan            <= pat_chan;
                    pend_flags           <= FLG_ACT;
                    quiet_seen[pat_chan] <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/evq_prio_sel.sv
module evq_prio_sel
    import evq_pkg::*;
(
    input  logic             ext_valid,
    input  logic [CH_W-1:0]  ext_chan,
    input  logic [FLG_W-1:0] ext_flags,
    input  logic             trk_valid,
    input  logic [CH_W-1:0]  trk_chan,
    input  logic [FLG_W-1:0] trk_flags,
    input  logic             grant,
    output logic             any_valid,
    output logic [CH_W-1:0]  sel_chan,
    output logic [FLG_W-1:0] sel_flags,
    output logic             ext_ready,
    output logic             trk_ready
);
    always_comb begin
        any_valid = ext_valid | trk_valid;
        if (ext_valid) begin
            sel_chan  = ext_chan;
            sel_flags = ext_flags;
        end else begin
            sel_chan  = trk_chan;
            sel_flags = trk_flags;
        end
        ext_ready = grant & ext_valid;
        trk_ready = grant & ~ext_valid & trk_valid;
    end

endmodule

// File: rtl/evq_ring_fsm.sv
module evq_ring_fsm
    import evq_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [AW-1:0]     base_addr,
    input  logic              any_valid,
    input  logic [CH_W-1:0]   sel_chan,
    input  logic [FLG_W-1:0]  sel_flags,
    input  logic [1:0]        slot_ctl_rd,
    output logic [AW-1:0]     mem_addr,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              grant,
    output logic              overflow
);
    evq_state_t    state, state_nx;
    logic [AW-1:0] wptr;
    logic          slot_held;
    logic          slot_wrap;

    assign slot_held = slot_ctl_rd[1];
    assign slot_wrap = slot_ctl_rd[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (any_valid) state_nx = ST_READ;
            ST_READ:  state_nx = ST_CHECK;
            ST_CHECK: state_nx = slot_held ? ST_READ : ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        mem_addr  = wptr;
        mem_we    = 1'b0;
        grant     = 1'b0;
        mem_wdata = pack_entry(sel_chan, sel_flags, slot_wrap);
        unique case (state)
            ST_IDLE:  ;
            ST_READ:  ;
            ST_CHECK: begin
                mem_we = !slot_held;
                grant  = !slot_held;
            end
            default:  ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr     <= base_addr;
            overflow <= 1'b0;
        end else if (state == ST_CHECK) begin
            if (slot_held) begin
                overflow <= 1'b1;
            end else if (slot_wrap) begin
                wptr <= base_addr;
            end else begin
                wptr <= wptr + 1'b1;
            end
        end
    end

endmodule

// File: rtl/evq_writer.sv
module evq_writer
    import evq_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [AW-1:0]     base_addr,
    input  logic              ev_valid,
    output logic              ev_ready,
    input  logic [7:0]        ev_chan,
    input  logic [7:0]        ev_flags,
    input  logic              pat_valid,
    output logic              pat_ready,
    input  logic [7:0]        pat_chan,
    input  logic [15:0]       pat_word,
    output logic [AW-1:0]     mem_addr,
    output logic              mem_we,
    output logic [31:0]       mem_wdata,
    input  logic [1:0]        slot_ctl_rd,
    output logic              overflow
);
    logic             trk_valid;
    logic             trk_ready;
    logic [CH_W-1:0]  trk_chan;
    logic [FLG_W-1:0] trk_flags;
    logic             any_valid;
    logic [CH_W-1:0]  sel_chan;
    logic [FLG_W-1:0] sel_flags;
    logic             grant;

    evq_idle_track #(.CHAN_W(CH_W)) u_track (
        .clk       (clk),
        .rst       (rst),
        .pat_valid (pat_valid),
        .pat_ready (pat_ready),
        .pat_chan  (pat_chan),
        .pat_word  (pat_word),
        .req_valid (trk_valid),
        .req_ready (trk_ready),
        .req_chan  (trk_chan),
        .req_flags (trk_flags)
    );

    evq_prio_sel u_sel (
        .ext_valid (ev_valid),
        .ext_chan  (ev_chan),
        .ext_flags (ev_flags),
        .trk_valid (trk_valid),
        .trk_chan  (trk_chan),
        .trk_flags (trk_flags),
        .grant     (grant),
        .any_valid (any_valid),
        .sel_chan  (sel_chan),
        .sel_flags (sel_flags),
        .ext_ready (ev_ready),
        .trk_ready (trk_ready)
    );

    evq_ring_fsm #(.AW(AW)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .base_addr   (base_addr),
        .any_valid   (any_valid),
        .sel_chan    (sel_chan),
        .sel_flags   (sel_flags),
        .slot_ctl_rd (slot_ctl_rd),
        .mem_addr    (mem_addr),
        .mem_we      (mem_we),
        .mem_wdata   (mem_wdata),
        .grant       (grant),
        .overflow    (overflow)
    );

endmodule

// File: rtl/evq_writer_chk.sv
module evq_writer_chk
    import evq_pkg::*;
#(
    parameter int AW = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [AW-1:0]     base_addr,
    input logic              ev_valid,
    input logic              ev_ready,
    input logic              trk_valid,
    input logic              trk_ready,
    input logic [FLG_W-1:0]  trk_flags,
    input logic [AW-1:0]     mem_addr,
    input logic              mem_we,
    input logic [WORD_W-1:0] mem_wdata,
    input logic [1:0]        slot_ctl_rd,
    input logic              overflow,
    input logic [AW-1:0]     wptr
);
    // R1
    entry_valid_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_wdata[VLD_BIT]);

    // R2
    rsv_zero_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> ((mem_wdata & RSV_MASK) == '0));

    // R2
    wrap_keep_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_wdata[WRAP_BIT] == slot_ctl_rd[0]));

    // R3
    ptr_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_we && slot_ctl_rd[0]) |=> (wptr == $past(base_addr)));

    // R3
    ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_we && !slot_ctl_rd[0]) |=> (wptr == AW'($past(mem_addr) + 1'b1)));

    // R4
    no_overwrite_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> !slot_ctl_rd[1]);

    // R4
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        $past(overflow) |-> overflow);

    // R5
    one_grant_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ev_ready, trk_ready}));

    // R5
    ext_first_chk: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && trk_valid && (ev_ready || trk_ready)) |-> ev_ready);

    // R6
    trk_kind_chk: assert property (@(posedge clk) disable iff (rst)
        trk_valid |-> (trk_flags == FLG_ACT || trk_flags == FLG_QUIET));

    // R8
    ovf_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !overflow);

    // R9
    read_first_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (!$past(mem_we) && mem_addr == $past(mem_addr)));

endmodule

bind evq_writer evq_writer_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .base_addr   (base_addr),
    .ev_valid    (ev_valid),
    .ev_ready    (ev_ready),
    .trk_valid   (trk_valid),
    .trk_ready   (trk_ready),
    .trk_flags   (trk_flags),
    .mem_addr    (mem_addr),
    .mem_we      (mem_we),
    .mem_wdata   (mem_wdata),
    .slot_ctl_rd (slot_ctl_rd),
    .overflow    (overflow),
    .wptr        (u_fsm.wptr)
);

// File: tb/evq_writer_tb.sv
module evq_writer_tb_top;

    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;
    localparam int LAST  = 9;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] base_addr = AW'(4);
    logic          ev_valid = 1'b0;
    logic          ev_ready;
    logic [7:0]    ev_chan = '0;
    logic [7:0]    ev_flags = '0;
    logic          pat_valid = 1'b0;
    logic          pat_ready;
    logic [7:0]    pat_chan = '0;
    logic [15:0]   pat_word = '0;
    logic [AW-1:0] mem_addr;
    logic          mem_we;
    logic [31:0]   mem_wdata;
    logic [31:0]   rd_q = '0;
    logic          overflow;

    logic          tb_init = 1'b0;
    logic          tb_clr  = 1'b0;
    logic          tb_set  = 1'b0;
    logic [AW-1:0] tb_idx  = '0;
    logic [31:0]   tb_val  = '0;
    logic [31:0]   mem [DEPTH];

    int errors = 0;
    int checks = 0;
    int slot   = 4;

    always #5 clk = ~clk;

    evq_writer #(.AW(AW)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .base_addr   (base_addr),
        .ev_valid    (ev_valid),
        .ev_ready    (ev_ready),
        .ev_chan     (ev_chan),
        .ev_flags    (ev_flags),
        .pat_valid   (pat_valid),
        .pat_ready   (pat_ready),
        .pat_chan    (pat_chan),
        .pat_word    (pat_word),
        .mem_addr    (mem_addr),
        .mem_we      (mem_we),
        .mem_wdata   (mem_wdata),
        .slot_ctl_rd (rd_q[31:30]),
        .overflow    (overflow)
    );

    // RAM model plus software-side slot access
    always @(posedge clk) begin
        if (tb_init) begin
            for (int k = 0; k < DEPTH; k++) mem[k] <= (k == LAST) ? 32'h4000_0000 : 32'h0;
        end else begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            else        rd_q <= mem[mem_addr];
            if (tb_clr) mem[tb_idx][31] <= 1'b0;
            if (tb_set) mem[tb_idx] <= tb_val;
        end
    end

    // channel, flags
    localparam logic [15:0] VEC [7] = '{
        16'h00_01, 16'hFF_80, 16'h5A_FF, 16'h01_40,
        16'h80_3F, 16'h33_24, 16'hC3_C0
    };

    function automatic logic [31:0] exp_word(input logic [7:0] c, input logic [7:0] f, input logic w);
        logic [31:0] r;
        r = 32'h8000_0000;
        r[30] = w;
        r[25:24] = f[7:6];
        r[21:16] = f[5:0];
        r[12:5] = c;
        return r;
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_ev(input logic [7:0] c, input logic [7:0] f);
        ev_chan = c; ev_flags = f; ev_valid = 1'b1;
        do @(negedge clk); while (!ev_ready);
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    task automatic send_pat(input logic [7:0] c, input logic [15:0] p);
        while (!pat_ready) @(negedge clk);
        pat_chan = c; pat_word = p; pat_valid = 1'b1;
        @(negedge clk);
        pat_valid = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic release_slot(input int idx);
        tb_idx = AW'(idx); tb_clr = 1'b1;
        @(negedge clk);
        tb_clr = 1'b0;
    endtask

    function automatic int next_slot(input int s);
        return (s == LAST) ? int'(base_addr) : s + 1;
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        int seen;
        @(negedge clk);
        tb_init = 1'b1;
        @(negedge clk);
        tb_init = 1'b0;
        settle(2);
        rst = 1'b0;
        @(negedge clk);
        // R8 / R9 reset state
        chk(32'(overflow), 32'h0, "R8 overflow after reset");
        chk(32'(ev_ready), 32'h0, "R8 ev_ready after reset");
        chk(32'(pat_ready), 32'h1, "R8 pat_ready after reset");
        chk(32'(mem_we), 32'h0, "R9 no write when idle");

        // R1 R2 R3: vector walk across the wrap slot
        for (int i = 0; i < 7; i++) begin
            send_ev(VEC[i][15:8], VEC[i][7:0]);
            chk(mem[slot], exp_word(VEC[i][15:8], VEC[i][7:0], slot == LAST),
                (slot == LAST) ? "R2 wrap slot record" : "R1 R3 record");
            release_slot(slot);
            slot = next_slot(slot);
        end
        chk(32'(slot), 32'd5, "R3 pointer after wrap");

        // R4: unreleased slot blocks the write
        tb_idx = AW'(slot); tb_val = 32'h8000_0ABC; tb_set = 1'b1;
        @(negedge clk);
        tb_set = 1'b0;
        fork
            send_ev(8'h77, 8'h02);
        join_none
        seen = 0;
        repeat (20) begin
            @(negedge clk);
            if (ev_ready) seen++;
        end
        chk(32'(seen), 32'h0, "R4 ready withheld");
        chk(32'(overflow), 32'h1, "R4 overflow set");
        chk(mem[slot], 32'h8000_0ABC, "R4 slot kept");
        release_slot(slot);
        wait fork;
        chk(mem[slot], exp_word(8'h77, 8'h02, 1'b0), "R4 write after release");
        chk(32'(overflow), 32'h1, "R4 overflow sticky");
        release_slot(slot);
        slot = next_slot(slot);

        // R5 R7: simultaneous sources, external first
        fork
            send_ev(8'h21, 8'h44);
            send_pat(8'd2, 16'h1234);
        join
        settle(8);
        chk(mem[slot], exp_word(8'h21, 8'h44, 1'b0), "R5 external first");
        chk(mem[slot + 1], exp_word(8'd2, 8'h10, 1'b0), "R5 R7 tracker second");
        release_slot(slot);
        release_slot(slot + 1);
        slot = slot + 2;

        // R6: idle reporting
        send_pat(8'd3, 16'hFFFE);
        settle(8);
        chk(mem[slot], exp_word(8'd3, 8'h08, 1'b0), "R6 first idle");
        release_slot(slot);
        slot = next_slot(slot);
        send_pat(8'd3, 16'hFFFE);
        settle(8);
        chk(32'(mem[slot][31]), 32'h0, "R6 repeated idle ignored");
        send_pat(8'd3, 16'h7E7E);
        settle(8);
        chk(mem[slot], exp_word(8'd3, 8'h10, 1'b1), "R7 active record");
        release_slot(slot);
        slot = next_slot(slot);
        send_pat(8'd3, 16'hFFFE);
        settle(8);
        chk(mem[slot], exp_word(8'd3, 8'h08, 1'b0), "R6 idle rearmed");
        release_slot(slot);

        // R8: reset reloads pointer and clears idle history
        base_addr = AW'(10);
        rst = 1'b1;
        settle(3);
        rst = 1'b0;
        @(negedge clk);
        chk(32'(overflow), 32'h0, "R8 overflow cleared");
        send_ev(8'h0F, 8'h01);
        chk(mem[10], exp_word(8'h0F, 8'h01, 1'b0), "R8 pointer from base");
        send_pat(8'd3, 16'hFFFE);
        settle(8);
        chk(mem[11], exp_word(8'd3, 8'h08, 1'b0), "R8 idle history cleared");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule